// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block drives a 12-bit successive-approximation converter through a contiguous band of analog inputs. Software programs a first and a last channel, chooses one-shot or repeating operation and pulses a start input. The sequencer then hands the converter one channel at a time over a start/done handshake and files each returned sample in a slot for that channel. The converter itself is outside the block.

Each slot can be read at any time as a 16-bit word. The justification of that word is applied on the read path, so flipping the alignment bit re-justifies every stored sample at once. Turning the module off while a scan runs does not cut the scan short. The block lets the conversion already in flight return, throws that sample away, and only then drops busy and the enable readback. Software polls the enable readback to know when the clock may be gated.

The trigger-source and sample-clock fields are held and read back but have no effect inside the block.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `trg_q` reads 16'h0007 (sample-clock field 3'b111, every other field 0). `busy` and `en_q` are 0, and every slot reads as invalid with data 0.
- R2: Trigger register layout: [13:11] last channel, [10:8] first channel, [7] alignment (1 = left), [6] mode (1 = repeat), [5:4] trigger source, [2:0] sample clock. Bits 15:14 and 3 always read 0. Writing 16'hFFFF while idle reads back 16'h3FF7.
- R3: A start pulse while enabled and idle sets `busy`. The block then issues conversions in ascending order from the first to the last channel, one `cnv_start` pulse per channel, and waits for `cnv_done` before it issues the next. In one-shot mode (bit 6 = 0), `busy` returns to 0 after the last channel's done.
- R4: In repeat mode (bit 6 = 1), the channel after the last channel is the first channel again, and the scan continues without stopping.
- R5: If the last channel is below the first channel, only the first channel is converted and the scan counts as complete.
- R6: With bit 7 = 0, `rd_data` is {4'b0, sample}.
- R7: With bit 7 = 1, `rd_data` is {sample, 4'b0}. A change of bit 7 re-justifies the readback of samples already stored and leaves the samples unchanged.
- R8: A slot's valid flag is set when its sample is written and cleared by `rd_en` on that slot. If the write and the clearing read fall in the same cycle, the flag stays set and the data is the new sample.
- R9: Writes to the trigger register while `busy` is 1 are ignored.
- R10: Writing 0 to the enable while `busy` leaves `en_q` and `busy` at 1 until the in-flight `cnv_done` arrives. That sample is discarded: the slot's data and flag are unchanged. `busy` and `en_q` then fall together. The same happens when the disable write and `cnv_done` share a cycle.
- R11: Writing 0 to the enable while idle clears `en_q` on the next cycle.
- R12: `scan_go` has no effect while `en_q` is 0 or while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Enable write strobe |
| en_wdata | input | 1 | Enable value to write |
| en_q | output | 1 | Enable readback; falls only after termination |
| trg_wr | input | 1 | Trigger register write strobe |
| trg_wdata | input | 16 | Trigger register write value |
| trg_q | output | 16 | Trigger register readback |
| scan_go | input | 1 | Start-of-scan pulse |
| busy | output | 1 | Scan in progress |
| rd_en | input | 1 | Read strobe; clears the selected slot's valid flag |
| rd_ch | input | 3 | Slot selected for readback |
| rd_valid | output | 1 | Valid flag of the selected slot |
| rd_data | output | 16 | Justified sample of the selected slot |
| cnv_start | output | 1 | Conversion request to the converter |
| cnv_ch | output | 3 | Channel for the conversion request |
| cnv_done | input | 1 | Conversion complete pulse |
| cnv_data | input | 12 | Converted sample |

## Verification
The enable-off write and the converter's done pulse can land on the same edge. The sequencer must then treat that done as the in-flight one to discard, not as a sample to store. The bench runs a repeating scan and waits until it sees `cnv_done` high. In that same cycle it drives the disable write. It then checks that `busy` and `en_q` are both low one cycle later and that the slot still holds its previous sample. A second collision, a clearing read on the very slot being written, is provoked the same way and judged by the flag staying set.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_ISSUE = 2'd1,
      SQ_WAIT  = 2'd2
   } sq_state_t;

   localparam int REG_W     = 16;
   localparam int FLD_W     = 3;
   localparam int LAST_LSB  = 11;
   localparam int FIRST_LSB = 8;
   localparam int ALIGN_BIT = 7;
   localparam int MODE_BIT  = 6;
   localparam int TSRC_LSB  = 4;
   localparam int SCLK_LSB  = 0;

endpackage

// File: rtl/adc_scan_trg.sv
module adc_scan_trg
   import adc_scan_pkg::*;
#(
   parameter logic [FLD_W-1:0] SCLK_RST = 3'b111
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             lock,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] q,
   output logic [FLD_W-1:0] last_f,
   output logic [FLD_W-1:0] first_f,
   output logic             align_left,
   output logic             cont_mode
);

   logic [1:0]       tsrc_f;
   logic [FLD_W-1:0] sclk_f;
   logic             unused_rsvd;

   assign unused_rsvd = ^{wdata[15:14], wdata[3]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_f     <= '0;
         first_f    <= '0;
         align_left <= 1'b0;
         cont_mode  <= 1'b0;
         tsrc_f     <= '0;
         sclk_f     <= SCLK_RST;
      end else if (wr && !lock) begin
         last_f     <= wdata[LAST_LSB +: FLD_W];
         first_f    <= wdata[FIRST_LSB +: FLD_W];
         align_left <= wdata[ALIGN_BIT];
         cont_mode  <= wdata[MODE_BIT];
         tsrc_f     <= wdata[TSRC_LSB +: 2];
         sclk_f     <= wdata[SCLK_LSB +: FLD_W];
      end
   end

   assign q = {2'b00, last_f, first_f, align_left, cont_mode, tsrc_f, 1'b0, sclk_f};

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
   import adc_scan_pkg::*;
#(
   parameter int CH_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en_wr,
   input  logic            en_wdata,
   input  logic            scan_go,
   input  logic [CH_W-1:0] first_ch,
   input  logic [CH_W-1:0] last_ch,
   input  logic            cont_mode,
   input  logic            cnv_done,
   output logic            en_q,
   output logic            busy,
   output logic            cnv_start,
   output logic [CH_W-1:0] cnv_ch,
   output logic            res_wr
);

   sq_state_t       st;
   logic [CH_W-1:0] cur;
   logic            term_pend;
   logic            off_req;
   logic            on_req;
   logic            stop_now;
   logic            at_end;

   assign off_req  = en_wr && !en_wdata;
   assign on_req   = en_wr && en_wdata;
   assign stop_now = term_pend || off_req;
   assign at_end   = (cur == last_ch) || (last_ch < first_ch);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SQ_IDLE;
         cur       <= '0;
         term_pend <= 1'b0;
         en_q      <= 1'b0;
         busy      <= 1'b0;
      end else begin
         unique case (st)
            SQ_IDLE: begin
               if (off_req)     en_q <= 1'b0;
               else if (on_req) en_q <= 1'b1;
               if (scan_go && en_q && !off_req) begin
                  cur  <= first_ch;
                  busy <= 1'b1;
                  st   <= SQ_ISSUE;
               end
            end
            SQ_ISSUE: begin
               if (off_req) term_pend <= 1'b1;
               st <= SQ_WAIT;
            end
            SQ_WAIT: begin
               if (cnv_done) begin
                  if (stop_now) begin
                     term_pend <= 1'b0;
                     busy      <= 1'b0;
                     en_q      <= 1'b0;
                     st        <= SQ_IDLE;
                  end else if (at_end) begin
                     if (cont_mode) begin
                        cur <= first_ch;
                        st  <= SQ_ISSUE;
                     end else begin
                        busy <= 1'b0;
                        st   <= SQ_IDLE;
                     end
                  end else begin
                     cur <= cur + 1'b1;
                     st  <= SQ_ISSUE;
                  end
               end else if (off_req) begin
                  term_pend <= 1'b1;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign cnv_start = (st == SQ_ISSUE);
   assign cnv_ch    = cur;
   assign res_wr    = (st == SQ_WAIT) && cnv_done && !stop_now;

endmodule

// File: rtl/adc_scan_res.sv
module adc_scan_res #(
   parameter int NUM_CH = 8,
   parameter int RES_W  = 12,
   parameter int WORD_W = 16,
   parameter int CH_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CH_W-1:0]   wr_ch,
   input  logic [RES_W-1:0]  wr_data,
   input  logic              rd_en,
   input  logic [CH_W-1:0]   rd_ch,
   input  logic              align_left,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_data
);

   localparam int PAD = WORD_W - RES_W;

   logic [RES_W-1:0]  slot_w [NUM_CH];
   logic [NUM_CH-1:0] vld_w;
   logic [RES_W-1:0]  sel;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
      logic [RES_W-1:0] val;
      logic             v;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val <= '0;
            v   <= 1'b0;
         end else if (wr_en && (wr_ch == CH_W'(g))) begin
            val <= wr_data;
            v   <= 1'b1;
         end else if (rd_en && (rd_ch == CH_W'(g))) begin
            v   <= 1'b0;
         end
      end
      assign slot_w[g] = val;
      assign vld_w[g]  = v;
   end

   assign sel      = slot_w[rd_ch];
   assign rd_valid = vld_w[rd_ch];

   if (PAD == 0) begin : g_nopad
      logic unused_align;
      assign unused_align = align_left;
      assign rd_data      = sel;
   end else begin : g_pad
      assign rd_data = align_left ? {sel, {PAD{1'b0}}} : {{PAD{1'b0}}, sel};
   end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adc_scan_pkg::*;
#(
   parameter int               NUM_CH   = 8,
   parameter int               RES_W    = 12,
   parameter int               WORD_W   = 16,
   parameter logic [FLD_W-1:0] SCLK_RST = 3'b111,
   localparam int              CH_W     = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_wr,
   input  logic              en_wdata,
   output logic              en_q,
   input  logic              trg_wr,
   input  logic [REG_W-1:0]  trg_wdata,
   output logic [REG_W-1:0]  trg_q,
   input  logic              scan_go,
   output logic              busy,
   input  logic              rd_en,
   input  logic [CH_W-1:0]   rd_ch,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_data,
   output logic              cnv_start,
   output logic [CH_W-1:0]   cnv_ch,
   input  logic              cnv_done,
   input  logic [RES_W-1:0]  cnv_data
);

   if (RES_W > WORD_W) begin : g_bad_width
      $error("adc_scan_seq: RES_W must not exceed WORD_W");
   end
   if (NUM_CH != 2 && NUM_CH != 4 && NUM_CH != 8) begin : g_bad_count
      $error("adc_scan_seq: NUM_CH must be 2, 4 or 8");
   end

   logic [FLD_W-1:0] last_f;
   logic [FLD_W-1:0] first_f;
   logic             align_left;
   logic             cont_mode;
   logic             res_wr;

   adc_scan_trg #(.SCLK_RST(SCLK_RST)) u_trg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (trg_wr),
      .lock       (busy),
      .wdata      (trg_wdata),
      .q          (trg_q),
      .last_f     (last_f),
      .first_f    (first_f),
      .align_left (align_left),
      .cont_mode  (cont_mode)
   );

   adc_scan_fsm #(.CH_W(CH_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_wr     (en_wr),
      .en_wdata  (en_wdata),
      .scan_go   (scan_go),
      .first_ch  (first_f[CH_W-1:0]),
      .last_ch   (last_f[CH_W-1:0]),
      .cont_mode (cont_mode),
      .cnv_done  (cnv_done),
      .en_q      (en_q),
      .busy      (busy),
      .cnv_start (cnv_start),
      .cnv_ch    (cnv_ch),
      .res_wr    (res_wr)
   );

   adc_scan_res #(
      .NUM_CH (NUM_CH),
      .RES_W  (RES_W),
      .WORD_W (WORD_W),
      .CH_W   (CH_W)
   ) u_res (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (res_wr),
      .wr_ch      (cnv_ch),
      .wr_data    (cnv_data),
      .rd_en      (rd_en),
      .rd_ch      (rd_ch),
      .align_left (align_left),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data)
   );

endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
   parameter int CH_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            en_q,
   input logic            cnv_start,
   input logic [CH_W-1:0] cnv_ch,
   input logic [15:0]     trg_q
);

   p_busy_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> en_q);

   p_en_fall_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_q) |-> !busy);

   p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_start |-> busy);

   p_single_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_start |=> !cnv_start);

   p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnv_start && (trg_q[13:11] >= trg_q[10:8]))
      |-> ((cnv_ch >= trg_q[10:8]) && (cnv_ch <= trg_q[13:11])));

   p_inverted_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnv_start && (trg_q[13:11] < trg_q[10:8])) |-> (cnv_ch == trg_q[10:8]));

   p_trg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(trg_q));

endmodule

bind adc_scan_seq adc_scan_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .en_q      (en_q),
   .cnv_start (cnv_start),
   .cnv_ch    (cnv_ch),
   .trg_q     (trg_q)
);

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;

   localparam int LAT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_wr = 1'b0, en_wdata = 1'b0, en_q;
   logic        trg_wr = 1'b0;
   logic [15:0] trg_wdata = '0, trg_q;
   logic        scan_go = 1'b0, busy;
   logic        rd_en = 1'b0;
   logic [2:0]  rd_ch = '0;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic        cnv_start;
   logic [2:0]  cnv_ch;
   logic        cnv_done = 1'b0;
   logic [11:0] cnv_data = '0;

   always #10 clk = ~clk;

   adc_scan_seq u_dut (
      .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata), .en_q(en_q),
      .trg_wr(trg_wr), .trg_wdata(trg_wdata), .trg_q(trg_q), .scan_go(scan_go),
      .busy(busy), .rd_en(rd_en), .rd_ch(rd_ch), .rd_valid(rd_valid),
      .rd_data(rd_data), .cnv_start(cnv_start), .cnv_ch(cnv_ch),
      .cnv_done(cnv_done), .cnv_data(cnv_data)
   );

   int          errs = 0;
   int          chks = 0;
   int          q_exp[$];
   string       tag = "R3";
   logic [11:0] store [8];
   logic [11:0] prev_val = '0;
   int          last_done_ch = 0;
   int          done_cnt = 0;
   logic [8:0]  seq = '0;
   bit          pend = 1'b0;
   int          cnt = 0;
   logic [2:0]  pch = '0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      chks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // converter model and scoreboard monitor
   always @(negedge clk) begin
      cnv_done <= 1'b0;
      if (rst_n) begin
         if (pend) begin
            if (cnt == 0) begin
               logic [11:0] dv;
               dv = {pch, seq};
               seq++;
               prev_val     = store[pch];
               store[pch]   = dv;
               last_done_ch = int'(pch);
               done_cnt++;
               cnv_done <= 1'b1;
               cnv_data <= dv;
               pend = 1'b0;
            end else begin
               cnt--;
            end
         end
         if (cnv_start) begin
            pend = 1'b1;
            pch  = cnv_ch;
            cnt  = LAT;
            if (q_exp.size() == 0) begin
               check(1'b0, tag, "unexpected conversion start", int'(cnv_ch), -1);
            end else begin
               int e;
               e = q_exp.pop_front();
               check(int'(cnv_ch) == e, tag, "scan channel order", int'(cnv_ch), e);
            end
         end
      end
   end

   task automatic wtrg(input logic [15:0] v);
      @(negedge clk); trg_wr = 1'b1; trg_wdata = v;
      @(negedge clk); trg_wr = 1'b0;
   endtask

   task automatic wen(input logic b);
      @(negedge clk); en_wr = 1'b1; en_wdata = b;
      @(negedge clk); en_wr = 1'b0;
   endtask

   task automatic go();
      @(negedge clk); scan_go = 1'b1;
      @(negedge clk); scan_go = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      int n;
      n = 0;
      do begin @(negedge clk); n++; end while (busy && n < 500);
      #1;
      check(!busy, req, "busy after scan", int'(busy), 0);
   endtask

   task automatic rd(input int ch, output logic v, output logic [15:0] d);
      @(negedge clk); rd_ch = 3'(ch); #1;
      v = rd_valid; d = rd_data;
   endtask

   task automatic rdclr(input int ch);
      @(negedge clk); rd_ch = 3'(ch); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic push_range(input int a, input int b);
      for (int c = a; c <= b; c++) q_exp.push_back(c);
   endtask

   initial begin
      #(20 * 150000);
      check(1'b0, "R3", "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
   end

   initial begin
      logic        v;
      logic [15:0] d;
      for (int i = 0; i < 8; i++) store[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check(trg_q == 16'h0007, "R1", "trg reset", int'(trg_q), 16'h0007);
      check(!busy && !en_q, "R1", "busy/en reset", int'({busy, en_q}), 0);
      rd(0, v, d);
      check(!v && d == 16'h0, "R1", "slot reset", int'({v, d}), 0);

      // R2 reserved bits
      wtrg(16'hFFFF); #1;
      check(trg_q == 16'h3FF7, "R2", "reserved bits read 0", int'(trg_q), 16'h3FF7);

      // R12 start while disabled
      wtrg(16'h2A07);
      go(); repeat (3) @(negedge clk); #1;
      check(!busy, "R12", "go ignored while disabled", int'(busy), 0);

      // R3 one-shot 2..5, R6 right alignment
      wen(1'b1);
      push_range(2, 5);
      go();
      wait_idle("R3");
      check(q_exp.size() == 0, "R3", "all channels issued", q_exp.size(), 0);
      for (int c = 2; c <= 5; c++) begin
         rd(c, v, d);
         check(v && d == {4'h0, store[c]}, "R6", "right-justified slot",
               int'(d), int'({4'h0, store[c]}));
      end
      rd(0, v, d);
      check(!v, "R3", "slot outside range untouched", int'(v), 0);

      // R7 left alignment applied to stored data
      wtrg(16'h2A87);
      rd(3, v, d);
      check(d == {store[3], 4'h0}, "R7", "left-justified slot", int'(d), int'({store[3], 4'h0}));
      wtrg(16'h2A07);
      rd(3, v, d);
      check(d == {4'h0, store[3]}, "R7", "back to right", int'(d), int'({4'h0, store[3]}));

      // R8 read clears valid
      rdclr(2);
      rd(2, v, d);
      check(!v, "R8", "valid cleared by read", int'(v), 0);

      // R5 inverted range
      tag = "R5";
      wtrg(16'h0E07);
      q_exp.push_back(6);
      go();
      wait_idle("R5");
      check(q_exp.size() == 0, "R5", "only first channel", q_exp.size(), 0);
      rd(6, v, d);
      check(v && d == {4'h0, store[6]}, "R5", "first channel stored", int'(d), int'({4'h0, store[6]}));

      // R10 disable with conversion in flight, one-shot channel 4
      tag = "R10";
      wtrg(16'h2407);
      rdclr(4);
      q_exp.push_back(4);
      go();
      begin
         logic [11:0] keep;
         keep = store[4];
         wen(1'b0); #1;
         check(en_q && busy, "R10", "enable held while in flight", int'({en_q, busy}), 3);
         wait_idle("R10");
         check(!en_q, "R10", "enable dropped after termination", int'(en_q), 0);
         store[last_done_ch] = prev_val;
         rd(4, v, d);
         check(!v && d == {4'h0, keep}, "R10", "in-flight sample discarded",
               int'({v, d}), int'({4'h0, keep}));
      end

      // R4 repeating scan 0..1, R9 and R12 while busy, then collision
      tag = "R4";
      wen(1'b1);
      wtrg(16'h0847);
      for (int k = 0; k < 20; k++) push_range(0, 1);
      begin
         int base;
         base = done_cnt;
         go();
         do begin @(negedge clk); #1; end while (done_cnt < base + 2);
         wtrg(16'h3F00); #1;
         check(trg_q == 16'h0847, "R9", "trg write ignored while busy", int'(trg_q), 16'h0847);
         go();
         do begin @(negedge clk); #1; end while (!(cnv_done && done_cnt >= base + 5));
         check(done_cnt >= base + 5, "R4", "scan wraps and repeats", done_cnt - base, 5);
         en_wr = 1'b1; en_wdata = 1'b0;
         @(negedge clk); en_wr = 1'b0; #1;
         check(!busy && !en_q, "R10", "disable on done edge terminates", int'({busy, en_q}), 0);
         store[last_done_ch] = prev_val;
         rd(last_done_ch, v, d);
         check(d == {4'h0, store[last_done_ch]}, "R10", "colliding sample discarded",
               int'(d), int'({4'h0, store[last_done_ch]}));
         repeat (LAT + 3) @(negedge clk);
         q_exp.delete();
      end

      // R8 write and clearing read in the same cycle
      tag = "R8";
      wen(1'b1);
      wtrg(16'h3F07);
      q_exp.push_back(7);
      go();
      do begin @(negedge clk); #1; end while (!cnv_done);
      rd_ch = 3'd7; rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0; #1;
      check(rd_valid && rd_data == {4'h0, store[7]}, "R8", "write wins over clear",
            int'({rd_valid, rd_data}), int'({1'b1, 4'h0, store[7]}));
      rdclr(7);
      rd(7, v, d);
      check(!v, "R8", "later read clears", int'(v), 0);

      // R11 disable while idle
      wait_idle("R3");
      wen(1'b0); #1;
      check(!en_q, "R11", "idle disable immediate", int'(en_q), 0);

      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
   end

endmodule